// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage In-Order Pipeline

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and turns fault flags from the first four stages into a precise trap. Each stage reports a flag, a 4-bit cause and the PC of the instruction it holds. The execute stage also reports a branch that resolved as mispredicted. The block answers with a kill signal for each flagging stage, a hold on fetch, a one-cycle redirect to a fixed handler address, and two trap registers: the faulting PC (EPC) and the cause.

When a fault is accepted, the faulting instruction and everything younger is killed at once. Fetch is held so that nothing new enters, and the older instructions still in the pipeline are allowed to drain through writeback. Only then is the handler entered. When several flags compete, the oldest instruction in program order wins. That is the deepest stage, whichever fault happened to appear first in time. Faults raised on the wrong side of a mispredicted branch are discarded. The datapath, the register file and the return from the handler sit outside the block.

Top module: `ptrap_ctrl`

## Requirements
- R1: When several stages flag in one cycle, the accepted fault is the one in the deepest stage. Flag and kill bit k index the stages as 0 fetch, 1 decode, 2 execute and 3 memory.
- R2: A fault accepted from stage S causes the redirect exactly 4-S cycles after the flag cycle. By then every older instruction has left writeback, and neither the faulting instruction nor any younger one ever commits.
- R3: In the cycle a fault from stage S is accepted, kill bits 0 through S are set and the deeper kill bits are clear.
- R4: The fetch hold is high from the accept cycle up to the cycle before the redirect, and low in the redirect cycle.
- R5: At the redirect the EPC takes the faulting instruction's own PC and the cause register takes its code (1 illegal opcode, 2 divide by zero, 3 TLB miss, 4 misaligned access). Both are visible from the next cycle and keep their values at all other times.
- R6: A mispredict in execute sets kill bits 0 and 1 in the same cycle, and any fetch or decode flag in that cycle is never reported.
- R7: A pending fault whose instruction is younger than a branch that mispredicts in execute during the drain is dropped. There is no redirect, the trap registers keep their values and the fetch hold is released.
- R8: While a fault is pending, flags from stages at or above the pending instruction's slot are ignored.
- R9: While a fault is pending, a flag from a stage deeper than the pending slot replaces it, and the redirect timing follows the new fault.
- R10: The redirect lasts exactly one cycle and carries the HANDLER_PC parameter, and the fetch stage holds the handler instruction in the following cycle.
- R11: During reset no redirect, fetch hold or kill is driven, and EPC and cause read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 4 | Fault flag per stage, bit k = stage k |
| exc_cause_i | input | 16 | Packed 4-bit cause per stage, stage k at bits 4k+3:4k |
| exc_pc_i | input | 128 | Packed 32-bit PC per stage, stage k at bits 32k+31:32k |
| mispredict_i | input | 1 | Branch in execute resolved as mispredicted |
| stall_fetch_o | output | 1 | No new instruction enters fetch, fetch PC held |
| flush_o | output | 4 | Kill the instruction in stage k |
| redirect_o | output | 1 | One-cycle handler redirect |
| redirect_pc_o | output | 32 | Handler address while redirect_o is high, else zero |
| epc_o | output | 32 | PC of the last trapped instruction |
| cause_o | output | 4 | Cause code of the last trapped instruction |

## Verification
On every cycle, the assertions check that the accepted flag has no deeper competitor and that its own stage is killed. They also check that the redirect never lasts past one cycle, that fetch stays held in the cycle after an accept, that no redirect follows an accept too early or follows a wrong-path cancel, and that the trap registers change only at a redirect. Only the bench scenarios, which run a small pipeline model, can show which instructions actually commit, the exact redirect cycle for each stage, and the choice between same-cycle and later-arriving older faults. The same holds for ignoring younger flags and for dropping a fault behind a mispredicted branch.

// File: rtl/ptrap_pkg.sv
package ptrap_pkg;

  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'h0,
    CAUSE_ILLEGAL  = 4'h1,
    CAUSE_DIVZERO  = 4'h2,
    CAUSE_TLBMISS  = 4'h3,
    CAUSE_MISALIGN = 4'h4
  } trap_cause_e;

  typedef enum logic {
    SEQ_RUN   = 1'b0,
    SEQ_DRAIN = 1'b1
  } seq_state_e;

endpackage

// File: rtl/ptrap_pick.sv
module ptrap_pick #(
  parameter int NSRC = 4,
  parameter int CW   = 4,
  parameter int AW   = 32,
  parameter int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    cand_i,
  input  logic [NSRC*CW-1:0] cause_i,
  input  logic [NSRC*AW-1:0] pc_i,
  output logic               hit_o,
  output logic [IW-1:0]      idx_o,
  output logic [CW-1:0]      cause_o,
  output logic [AW-1:0]      pc_o
);

  logic [CW-1:0] cause_slot [NSRC];
  logic [AW-1:0] pc_slot    [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign cause_slot[g] = cause_i[g*CW +: CW];
    assign pc_slot[g]    = pc_i[g*AW +: AW];
  end

  // Scan from the shallowest stage upwards so the deepest candidate wins.
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    cause_o = '0;
    pc_o    = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (cand_i[k]) begin
        hit_o   = 1'b1;
        idx_o   = IW'(k);
        cause_o = cause_slot[k];
        pc_o    = pc_slot[k];
      end
    end
  end

endmodule

// File: rtl/ptrap_seq.sv
module ptrap_seq
  import ptrap_pkg::*;
#(
  parameter int NSTAGE   = 5,
  parameter int CW       = 4,
  parameter int AW       = 32,
  parameter int BR_STAGE = 2,
  parameter int NSRC     = NSTAGE - 1,
  parameter int IW       = (NSRC > 1) ? $clog2(NSRC) : 1,
  parameter int PW       = $clog2(NSTAGE + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] exc_valid_i,
  input  logic            mispredict_i,
  input  logic            hit_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [CW-1:0]   sel_cause_i,
  input  logic [AW-1:0]   sel_pc_i,
  output logic [NSRC-1:0] cand_o,
  output logic [NSRC-1:0] flush_o,
  output logic            stall_fetch_o,
  output logic            trap_o,
  output logic [CW-1:0]   pend_cause_o,
  output logic [AW-1:0]   pend_pc_o
);

  localparam logic [PW-1:0] LAST_SLOT = PW'(NSTAGE - 1);
  localparam logic [PW-1:0] BR_SLOT   = PW'(BR_STAGE);

  seq_state_e    state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [CW-1:0] pend_cause_q;
  logic [AW-1:0] pend_pc_q;
  logic          draining;
  logic          cancel;

  assign draining = (state_q == SEQ_DRAIN);
  assign trap_o   = draining && (pos_q == LAST_SLOT) && !hit_i;
  assign cancel   = draining && mispredict_i && (pos_q < BR_SLOT) && !hit_i;

  // Per-stage filter: only instructions older than the pending slot, and
  // never the wrong-path stages behind a mispredicting branch.
  for (genvar k = 0; k < NSRC; k++) begin : g_stage
    logic older;
    logic wrong_path;
    assign older      = (state_q == SEQ_RUN) || (PW'(k) > pos_q);
    assign wrong_path = mispredict_i && (k < BR_STAGE);
    assign cand_o[k]  = exc_valid_i[k] && older && !wrong_path;
    assign flush_o[k] = (hit_i && (IW'(k) <= idx_i)) || wrong_path;
  end

  assign stall_fetch_o = hit_i || (draining && !trap_o && !cancel);
  assign pend_cause_o  = pend_cause_q;
  assign pend_pc_o     = pend_pc_q;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    if (hit_i) begin
      state_d = SEQ_DRAIN;
      pos_d   = PW'(idx_i) + PW'(1);
    end else if (trap_o || cancel) begin
      state_d = SEQ_RUN;
      pos_d   = '0;
    end else if (draining) begin
      pos_d   = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_RUN;
      pos_q        <= '0;
      pend_cause_q <= '0;
      pend_pc_q    <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      if (hit_i) begin
        pend_cause_q <= sel_cause_i;
        pend_pc_q    <= sel_pc_i;
      end
    end
  end

  AST_DRAIN_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && (idx_i != IW'(NSRC - 1))) |=> !trap_o); // R2

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (stall_fetch_o || trap_o || mispredict_i)); // R4

  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && mispredict_i && (pos_q < BR_SLOT) && !hit_i) |=> !trap_o); // R7

endmodule

// File: rtl/ptrap_regs.sv
module ptrap_regs #(
  parameter int CW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] cause_i,
  input  logic [AW-1:0] pc_i,
  output logic [CW-1:0] cause_o,
  output logic [AW-1:0] epc_o
);

  logic [CW-1:0] cause_q;
  logic [AW-1:0] epc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (load_i) begin
      cause_q <= cause_i;
      epc_q   <= pc_i;
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;

  AST_TRAP_REGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (epc_o == $past(pc_i)) && (cause_o == $past(cause_i))); // R5

  AST_TRAP_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(epc_o) && $stable(cause_o))); // R5

endmodule

// File: rtl/ptrap_ctrl.sv
module ptrap_ctrl #(
  parameter int          NSTAGE     = 5,
  parameter int          CW         = 4,
  parameter int          AW         = 32,
  parameter int          BR_STAGE   = 2,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0800
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSTAGE-2:0]          exc_valid_i,
  input  logic [(NSTAGE-1)*CW-1:0]   exc_cause_i,
  input  logic [(NSTAGE-1)*AW-1:0]   exc_pc_i,
  input  logic                       mispredict_i,
  output logic                       stall_fetch_o,
  output logic [NSTAGE-2:0]          flush_o,
  output logic                       redirect_o,
  output logic [AW-1:0]              redirect_pc_o,
  output logic [AW-1:0]              epc_o,
  output logic [CW-1:0]              cause_o
);

  localparam int NSRC = NSTAGE - 1;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PW   = $clog2(NSTAGE + 1);

  logic [NSRC-1:0] cand;
  logic            hit;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   sel_cause;
  logic [AW-1:0]   sel_pc;
  logic [CW-1:0]   pend_cause;
  logic [AW-1:0]   pend_pc;
  logic            trap;

  ptrap_pick #(.NSRC(NSRC), .CW(CW), .AW(AW), .IW(IW)) pick_i (
    .cand_i  (cand),
    .cause_i (exc_cause_i),
    .pc_i    (exc_pc_i),
    .hit_o   (hit),
    .idx_o   (idx),
    .cause_o (sel_cause),
    .pc_o    (sel_pc)
  );

  ptrap_seq #(
    .NSTAGE(NSTAGE), .CW(CW), .AW(AW), .BR_STAGE(BR_STAGE),
    .NSRC(NSRC), .IW(IW), .PW(PW)
  ) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_valid_i   (exc_valid_i),
    .mispredict_i  (mispredict_i),
    .hit_i         (hit),
    .idx_i         (idx),
    .sel_cause_i   (sel_cause),
    .sel_pc_i      (sel_pc),
    .cand_o        (cand),
    .flush_o       (flush_o),
    .stall_fetch_o (stall_fetch_o),
    .trap_o        (trap),
    .pend_cause_o  (pend_cause),
    .pend_pc_o     (pend_pc)
  );

  ptrap_regs #(.CW(CW), .AW(AW)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (trap),
    .cause_i (pend_cause),
    .pc_i    (pend_pc),
    .cause_o (cause_o),
    .epc_o   (epc_o)
  );

  assign redirect_o    = trap;
  assign redirect_pc_o = trap ? AW'(HANDLER_PC) : '0;

  AST_OLDEST_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cand[idx] && (((cand >> idx) >> 1) == '0))); // R1

  AST_SELF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> flush_o[idx]); // R3

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o); // R10

endmodule

// File: tb/ptrap_ctrl_tb_top.sv
module ptrap_ctrl_tb_top;
  import ptrap_pkg::*;

  localparam int          NST  = 5;
  localparam int          NSRC = NST - 1;
  localparam logic [31:0] HND  = 32'h0000_0800;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic clk;
  logic rst_n;
  logic [NSRC-1:0]   exc_valid;
  logic [NSRC*4-1:0] exc_cause;
  logic [NSRC*32-1:0] exc_pc;
  logic              mispredict;
  logic              stall_fetch;
  logic [NSRC-1:0]   flush;
  logic              redirect;
  logic [31:0]       redirect_pc;
  logic [31:0]       epc;
  logic [3:0]        cause;

  ptrap_ctrl #(.NSTAGE(NST), .CW(4), .AW(32), .BR_STAGE(2), .HANDLER_PC(HND)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .exc_valid_i (exc_valid), .exc_cause_i (exc_cause), .exc_pc_i (exc_pc),
    .mispredict_i (mispredict),
    .stall_fetch_o (stall_fetch), .flush_o (flush),
    .redirect_o (redirect), .redirect_pc_o (redirect_pc),
    .epc_o (epc), .cause_o (cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Scenario tables
  logic f1_en, f2_en, br_en, inj_en;
  logic [31:0] f1_pc, f2_pc, br_pc, inj_pc;
  int f1_stage, f2_stage, inj_stage, inj_cyc, w_cyc;
  logic [3:0] f1_cause, f2_cause, inj_cause;

  // Pipeline model
  logic        sv  [NST];
  logic [31:0] spc [NST];
  logic [31:0] fpc;
  int cyc, prog_n, hnd_n;
  logic [31:0] prog_last;

  // Observations
  int rd_n, rd_cyc, stall_n;
  logic [31:0] rd_pc, if_after;
  logic [NSRC-1:0] w_flush;

  int n_chk = 0;
  int n_fail = 0;

  always_comb begin
    exc_valid = '0;
    exc_cause = '0;
    exc_pc    = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (sv[k] && f1_en && f1_stage == k && spc[k] == f1_pc) begin
        exc_valid[k] = 1'b1; exc_cause[k*4 +: 4] = f1_cause; exc_pc[k*32 +: 32] = spc[k];
      end
      if (sv[k] && f2_en && f2_stage == k && spc[k] == f2_pc) begin
        exc_valid[k] = 1'b1; exc_cause[k*4 +: 4] = f2_cause; exc_pc[k*32 +: 32] = spc[k];
      end
      if (inj_en && cyc == inj_cyc && inj_stage == k) begin
        exc_valid[k] = 1'b1; exc_cause[k*4 +: 4] = inj_cause; exc_pc[k*32 +: 32] = inj_pc;
      end
    end
    mispredict = br_en && sv[2] && (spc[2] == br_pc);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NST; k++) begin sv[k] <= 1'b0; spc[k] <= '0; end
      fpc <= BASE; cyc <= 0; prog_n <= 0; hnd_n <= 0; prog_last <= '0;
    end else begin
      cyc <= cyc + 1;
      if (sv[NST-1]) begin
        if (spc[NST-1] < HND) begin prog_n <= prog_n + 1; prog_last <= spc[NST-1]; end
        else hnd_n <= hnd_n + 1;
      end
      for (int k = NST - 1; k >= 1; k--) begin
        sv[k]  <= sv[k-1] && !flush[k-1];
        spc[k] <= spc[k-1];
      end
      if (redirect) begin
        sv[0] <= 1'b1; spc[0] <= redirect_pc; fpc <= redirect_pc + 32'd4;
      end else if (stall_fetch) begin
        sv[0] <= 1'b0;
      end else begin
        sv[0] <= 1'b1; spc[0] <= fpc; fpc <= fpc + 32'd4;
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n = 0; rd_cyc = -10; stall_n = 0; rd_pc = '0; if_after = '0; w_flush = '0;
    end else begin
      if (redirect) begin rd_n = rd_n + 1; rd_cyc = cyc; rd_pc = redirect_pc; end
      if (stall_fetch) stall_n = stall_n + 1;
      if (cyc == w_cyc) w_flush = flush;
      if (rd_n > 0 && cyc == rd_cyc + 1) if_after = sv[0] ? spc[0] : 32'hFFFF_FFFF;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic begin_reset();
    @(negedge clk);
    rst_n = 1'b0;
    f1_en = 0; f2_en = 0; br_en = 0; inj_en = 0;
    f1_pc = '0; f2_pc = '0; br_pc = '0; inj_pc = '0;
    f1_stage = 0; f2_stage = 0; inj_stage = 0; inj_cyc = -1; w_cyc = -1;
    f1_cause = '0; f2_cause = '0; inj_cause = '0;
  endtask

  task automatic end_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [31:0] ipc(input int i);
    return BASE + 32'(4 * i);
  endfunction

  task automatic t_reset_state();
    begin_reset();
    @(negedge clk); #1;
    chk("R11 redirect in reset", 32'(redirect), 32'd0);
    chk("R11 stall in reset", 32'(stall_fetch), 32'd0);
    chk("R11 flush in reset", 32'(flush), 32'd0);
    chk("R11 epc in reset", epc, 32'd0);
    chk("R11 cause in reset", 32'(cause), 32'd0);
  endtask

  task automatic t_single(input int f, input int s, input logic [3:0] c);
    begin_reset();
    f1_en = 1; f1_pc = ipc(f); f1_stage = s; f1_cause = c;
    w_cyc = f + s + 1;
    end_reset();
    run_cycles(f + 12);
    chk("R10 single redirect count", 32'(rd_n), 32'd1);
    chk("R2 redirect cycle", 32'(rd_cyc), 32'(f + 5));
    chk("R10 redirect pc", rd_pc, HND);
    chk("R10 fetch holds handler", if_after, HND);
    chk("R5 epc", epc, ipc(f));
    chk("R5 cause", 32'(cause), 32'(c));
    chk("R2 older commits", 32'(prog_n), 32'(f));
    chk("R2 last committed pc", prog_last, ipc(f - 1));
    chk("R3 kill mask", 32'(w_flush), 32'((1 << (s + 1)) - 1));
    chk("R4 fetch hold cycles", 32'(stall_n), 32'(4 - s));
    chk("R10 handler committed", 32'(hnd_n > 0), 32'd1);
  endtask

  task automatic t_same_cycle();
    begin_reset();
    f1_en = 1; f1_pc = ipc(5); f1_stage = 3; f1_cause = CAUSE_TLBMISS;
    f2_en = 1; f2_pc = ipc(7); f2_stage = 1; f2_cause = CAUSE_ILLEGAL;
    w_cyc = 9;
    end_reset();
    run_cycles(18);
    chk("R1 cause of deepest", 32'(cause), 32'(CAUSE_TLBMISS));
    chk("R1 epc of deepest", epc, ipc(5));
    chk("R1 redirect cycle", 32'(rd_cyc), 32'd10);
    chk("R1 kill mask", 32'(w_flush), 32'hF);
    chk("R1 older commits", 32'(prog_n), 32'd5);
  endtask

  task automatic t_older_replaces();
    begin_reset();
    f1_en = 1; f1_pc = ipc(8); f1_stage = 1; f1_cause = CAUSE_ILLEGAL;
    f2_en = 1; f2_pc = ipc(7); f2_stage = 3; f2_cause = CAUSE_TLBMISS;
    w_cyc = 11;
    end_reset();
    run_cycles(20);
    chk("R9 cause replaced", 32'(cause), 32'(CAUSE_TLBMISS));
    chk("R9 epc replaced", epc, ipc(7));
    chk("R9 redirect cycle", 32'(rd_cyc), 32'd12);
    chk("R9 redirect count", 32'(rd_n), 32'd1);
    chk("R9 older commits", 32'(prog_n), 32'd7);
    chk("R9 kill mask", 32'(w_flush), 32'hF);
  endtask

  task automatic t_younger_ignored();
    begin_reset();
    f1_en = 1; f1_pc = ipc(4); f1_stage = 2; f1_cause = CAUSE_DIVZERO;
    inj_en = 1; inj_cyc = 8; inj_stage = 2; inj_cause = CAUSE_ILLEGAL; inj_pc = 32'h0000_0DE0;
    end_reset();
    run_cycles(16);
    chk("R8 cause kept", 32'(cause), 32'(CAUSE_DIVZERO));
    chk("R8 epc kept", epc, ipc(4));
    chk("R8 redirect cycle", 32'(rd_cyc), 32'd9);
    chk("R8 redirect count", 32'(rd_n), 32'd1);
  endtask

  task automatic t_mispredict_same();
    begin_reset();
    br_en = 1; br_pc = ipc(5);
    f1_en = 1; f1_pc = ipc(6); f1_stage = 1; f1_cause = CAUSE_ILLEGAL;
    w_cyc = 8;
    end_reset();
    run_cycles(20);
    chk("R6 wrong-path kill", 32'(w_flush), 32'h3);
    chk("R6 no redirect", 32'(rd_n), 32'd0);
    chk("R6 cause untouched", 32'(cause), 32'd0);
    chk("R6 no fetch hold", 32'(stall_n), 32'd0);
  endtask

  task automatic t_mispredict_drain();
    begin_reset();
    br_en = 1; br_pc = ipc(5);
    f1_en = 1; f1_pc = ipc(6); f1_stage = 0; f1_cause = CAUSE_MISALIGN;
    end_reset();
    run_cycles(20);
    chk("R7 no redirect", 32'(rd_n), 32'd0);
    chk("R7 cause untouched", 32'(cause), 32'd0);
    chk("R7 epc untouched", epc, 32'd0);
    chk("R7 fetch hold released", 32'(stall_n), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_single(6, 2, CAUSE_DIVZERO);
    t_single(3, 0, CAUSE_MISALIGN);
    t_single(5, 1, CAUSE_ILLEGAL);
    t_single(4, 3, CAUSE_TLBMISS);
    t_same_cycle();
    t_older_replaces();
    t_younger_ignored();
    t_mispredict_same();
    t_mispredict_drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule